// File: doc/BRIEF.md
# Bus-Programmed Watchdog Timer

This block is a watchdog timer on a plain memory-mapped register bus. Software writes a timeout in ticks, sets the run bit, and then keeps writing a self-clearing restart bit before the count runs out. If it stops doing so, the block latches a sticky expiry flag. It then sends a one-clock request to the platform, either a reset or a shutdown, depending on an action bit that software sets.

The tick comes from a prescaler in the block. A two-bit select input divides the clock into a 1 s tick, the usual setting, or into 100 ms, 10 ms or 1 ms ticks. A hardware strap input can lock the watchdog off. Software sees that lock as a read-only status bit.

Top module: `wdt_mmio`

## Requirements
- R1: After reset the control word at offset 0x0 reads 0 (with the strap low), the count word at offset 0x4 reads 0x0000FFFF, and both request outputs are low.
- R2: The control word has run at bit 0, the sticky expiry flag at bit 1, the action select at bit 2 and the strap status at bit 3. The count word keeps bits 15:0 and reads 0 above them. Any other offset reads 0, and writes to it change nothing.
- R3: After a write that sets run and restart with a count of N, expiry happens on the Nth tick. Clearing run freezes the remaining count, and setting run again resumes from it.
- R4: tick_sel values 0, 1, 2 and 3 give a tick every DIV_1S, DIV_1S/10, DIV_1S/100 and DIV_1S/1000 clocks, with a minimum of 1. The prescaler restarts on every restart write.
- R5: On expiry the block sets the expiry flag and pulses exactly one request output for one clock. The output is rst_req when the action bit is 0 and shut_req when it is 1.
- R6: After expiry the counter stays halted, with no further requests, until the next restart write.
- R7: Writing 1 to bit 1 of the control word clears the expiry flag. Writing 0 leaves it unchanged.
- R8: Writing 1 to bit 7 of the control word reloads the counter from the count word. Bit 7 always reads 0.
- R9: A restart write that lands in the same clock as an expiry wins. No request is sent, the flag stays clear, and a full new count begins.
- R10: While strap_off is high, bit 3 of the control word reads 1, the counter never advances and no request is sent.
- R11: Bits 6:4 of the control word read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_sel | input | 2 | Tick period select |
| strap_off | input | 1 | Hardware strap that disables the watchdog |
| rst_req | output | 1 | One-clock reset request on expiry |
| shut_req | output | 1 | One-clock shutdown request on expiry |

## Verification
The countdown is run with short counts at the fastest tick. This checks the exact expiry cycle and shows an off-by-one tick apart from a correct count. A 10-clock tick separates the prescaler divide from the count itself. A run that is paused in mid-count and then resumed shows whether the remaining count is held or reloaded. A restart issued exactly on the expiry clock, another issued well before it, and a wait after expiry together tell a restart race apart from ordinary restarting and from the halt after expiry.

// File: rtl/wdt_mmio.sv
module wdt_mmio #(
  parameter int DIV_1S = 200_000_000,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [1:0]    tick_sel,
  input  logic          strap_off,
  output logic          rst_req,
  output logic          shut_req
);
  localparam int D0 = (DIV_1S < 1) ? 1 : DIV_1S;
  localparam int D1 = (D0 / 10 < 1) ? 1 : D0 / 10;
  localparam int D2 = (D0 / 100 < 1) ? 1 : D0 / 100;
  localparam int D3 = (D0 / 1000 < 1) ? 1 : D0 / 1000;
  localparam int PW = $clog2(D0 + 1);

  logic          run_q, fired_q, act_q, halted_q;
  logic [15:0]   count_q, cnt_q;
  logic [PW-1:0] presc_q, div_m1;
  logic          wr_ctl, wr_cnt, reload, active, tick, expire;
  logic          unused_bits;

  always_comb begin
    case (tick_sel)
      2'd0:    div_m1 = PW'(D0 - 1);
      2'd1:    div_m1 = PW'(D1 - 1);
      2'd2:    div_m1 = PW'(D2 - 1);
      default: div_m1 = PW'(D3 - 1);
    endcase
  end

  assign wr_ctl = bus_wr && bus_addr == AW'(0);
  assign wr_cnt = bus_wr && bus_addr == AW'(4);
  assign reload = wr_ctl && bus_wdata[7];
  assign active = run_q && !strap_off && !halted_q;
  assign tick   = active && presc_q == div_m1;
  assign expire = tick && cnt_q <= 16'd1 && !reload;
  assign unused_bits = ^{bus_wdata[31:16], bus_wdata[6:3]};

  always_comb begin
    if (bus_addr == AW'(0))
      bus_rdata = {28'd0, strap_off, act_q, fired_q, run_q};
    else if (bus_addr == AW'(4))
      bus_rdata = {16'd0, count_q};
    else
      bus_rdata = 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      fired_q  <= 1'b0;
      act_q    <= 1'b0;
      halted_q <= 1'b0;
      count_q  <= 16'hFFFF;
      cnt_q    <= 16'hFFFF;
      presc_q  <= '0;
      rst_req  <= 1'b0;
      shut_req <= 1'b0;
    end else begin
      if (wr_ctl) begin
        run_q <= bus_wdata[0];
        act_q <= bus_wdata[2];
      end
      if (wr_cnt) count_q <= bus_wdata[15:0];

      if (reload || !active || tick) presc_q <= '0;
      else presc_q <= presc_q + 1'b1;

      if (reload) cnt_q <= count_q;
      else if (tick && cnt_q != 16'd0) cnt_q <= cnt_q - 1'b1;

      if (reload) halted_q <= 1'b0;
      else if (expire) halted_q <= 1'b1;

      if (expire) fired_q <= 1'b1;
      else if (wr_ctl && bus_wdata[1]) fired_q <= 1'b0;

      rst_req  <= expire && !act_q;
      shut_req <= expire && act_q;
    end
  end
endmodule

module wdt_mmio_chk #(parameter int AW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          reload_bit,
  input logic [31:0]   bus_rdata,
  input logic          strap_off,
  input logic          fired_q,
  input logic          rst_req,
  input logic          shut_req
);
  // R5
  rst_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req);
  // R5
  shut_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n) shut_req |=> !shut_req);
  // R5
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rst_req && shut_req));
  // R5
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (rst_req || shut_req) |-> fired_q);
  // R9
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0) && reload_bit) |=> !(rst_req || shut_req));
  // R10
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_off && $past(strap_off)) |-> !(rst_req || shut_req));
  // R11
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(0)) |-> bus_rdata[31:4] == 28'd0);
endmodule

bind wdt_mmio wdt_mmio_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .reload_bit(bus_wdata[7]), .bus_rdata(bus_rdata), .strap_off(strap_off),
  .fired_q(fired_q), .rst_req(rst_req), .shut_req(shut_req)
);

// File: tb/sim_wdt_mmio.sv
`timescale 1ns/1ps
module sim_wdt_mmio;
  logic        clk = 0, rst_n = 0, bus_wr = 0, strap_off = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [1:0]  tick_sel = 2'd3;
  logic        rst_req, shut_req;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  wdt_mmio #(.DIV_1S(1000), .AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_sel(tick_sel),
    .strap_off(strap_off), .rst_req(rst_req), .shut_req(shut_req));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; write happens on the next posedge; returns at the negedge after it
  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata; bus_addr = 0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean();
    wr(4'h0, 32'h2); step(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 count", d, 32'hFFFF);
    chk("R1 outs", {rst_req, shut_req}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(4'h4, 32'hABCD_0005);
    rd(4'h4, d); chk("R2 count upper", d, 32'h5);
    wr(4'h0, 32'h81);
    step(4);
    chk("R3 early", {rst_req, shut_req}, 0);
    rd(4'h0, d); chk("R3 flag early", d[1], 0);
    step(1);
    chk("R5 rst pulse", {rst_req, shut_req}, 2'b10);
    rd(4'h0, d); chk("R5 flag", d, 32'h3);
    step(1);
    chk("R5 one clock", rst_req, 0);
    step(20);
    chk("R6 halted", {rst_req, shut_req}, 0);
    wr(4'h0, 32'h1);
    rd(4'h0, d); chk("R7 write0 keeps", d[1], 1);
    wr(4'h0, 32'h3);
    rd(4'h0, d); chk("R7 w1c", d[1], 0);
    step(10);
    chk("R6 no restart w/o reload", rst_req, 0);
    clean();
  endtask

  task automatic t_shut();
    wr(4'h4, 32'h3);
    wr(4'h0, 32'h85);
    step(2);
    chk("R5 shut early", shut_req, 0);
    step(1);
    chk("R5 shut pulse", {rst_req, shut_req}, 2'b01);
    clean();
  endtask

  task automatic t_pause();
    wr(4'h4, 32'd10);
    wr(4'h0, 32'h81);
    step(3);
    wr(4'h0, 32'h0);
    step(20);
    chk("R3 paused", {rst_req, shut_req}, 0);
    wr(4'h0, 32'h1);
    step(5);
    chk("R3 resume early", rst_req, 0);
    step(1);
    chk("R3 resume expiry", rst_req, 1);
    clean();
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(4'h4, 32'd3);
    wr(4'h0, 32'h81);
    step(2);
    wr(4'h0, 32'h81);
    chk("R9 no req", {rst_req, shut_req}, 0);
    rd(4'h0, d); chk("R9 flag clear", d[1], 0);
    step(2);
    chk("R9 full recount", rst_req, 0);
    step(1);
    chk("R9 expiry after recount", rst_req, 1);
    clean();
  endtask

  task automatic t_kick();
    wr(4'h4, 32'd4);
    wr(4'h0, 32'h81);
    for (int k = 0; k < 6; k++) begin
      step(2);
      wr(4'h0, 32'h81);
    end
    chk("R8 kicked", {rst_req, shut_req}, 0);
    clean();
  endtask

  task automatic t_presc();
    tick_sel = 2'd2;
    wr(4'h4, 32'd3);
    wr(4'h0, 32'h81);
    step(29);
    chk("R4 div10 early", rst_req, 0);
    step(1);
    chk("R4 div10 expiry", rst_req, 1);
    tick_sel = 2'd3;
    clean();
  endtask

  task automatic t_strap();
    logic [31:0] d;
    strap_off = 1;
    wr(4'h4, 32'd2);
    wr(4'h0, 32'h81);
    rd(4'h0, d); chk("R10 status", d, 32'h9);
    step(10);
    chk("R10 quiet", {rst_req, shut_req}, 0);
    wr(4'h0, 32'h0);
    strap_off = 0;
    clean();
  endtask

  task automatic t_bits();
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFF4);
    rd(4'h0, d); chk("R11 R8 reserved/reload read 0", d, 32'h4);
    wr(4'h4, 32'h0000_1234);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R2 unmapped read", d, 0);
    rd(4'h4, d); chk("R2 unmapped write ignored", d, 32'h1234);
    rd(4'h0, d); chk("R2 ctrl untouched", d, 32'h4);
    wr(4'h0, 32'h0);
    clean();
  endtask

  initial begin
    fork
      begin
        #20; @(negedge clk); rst_n = 1; @(negedge clk);
        t_reset(); t_basic(); t_shut(); t_pause(); t_race();
        t_kick(); t_presc(); t_strap(); t_bits();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule